// File: doc/BRIEF.md
# Three-Channel PWM Dead-Band Generator

This block sits between a PWM timer's compare logic and the gate drivers of three half bridges. For each of three channels it takes a single compare state and turns it into a complementary pair of active-high gate signals, a high-side gate and a low-side gate. Whenever one gate of a pair is about to turn on, the block can hold both gates off for a programmable number of timer ticks. This dead band keeps the two switches of a half bridge from ever conducting at the same time.

Only off-to-on transitions are delayed. The gate that turns off does so at once. A 50% duty input therefore gives each gate an on-time of half the period minus the dead band, and this holds in both center-aligned and edge-aligned timer modes. The countdown advances only on cycles where the timer's clock enable is high, so the dead band is counted in timer ticks. All three channels share one dead-band length. Each channel has its own enable and its own run flag. The countdowns have a dedicated clear input that is separate from the system reset.

Top module: `pwm_deadband`

## Requirements
- R1: After `rst`, every gate output is 0 and every run flag is 0. The gates stay 0 until the first cycle in which `tick_en` is 1; after that clock edge the gate that matches each compare state is driven.
- R2: With a channel's enable bit at 0, a change of its compare state shows on the gates at the next clock edge. A compare state of 1 drives the high-side gate, and a compare state of 0 drives the low-side gate.
- R3: With a channel's enable bit at 1 and a nonzero `dt_value` D, a compare change loads the channel's countdown with D at the next clock edge. The gate for the new state turns on at the clock edge of the D-th following cycle in which `tick_en` is 1.
- R4: The gate belonging to the old compare state turns off at the next clock edge after a compare change, whether or not the channel is enabled.
- R5: A channel's run flag is 1 exactly while its countdown is nonzero. While the flag is 1, both gates of that pair are 0.
- R6: The countdown changes only on cycles with `tick_en` at 1, unless it is being loaded or cleared. Without ticks it holds its value.
- R7: `cnt_clr` sets all countdowns to 0 at the next clock edge, which ends any running dead band. `cnt_clr` takes priority over a load. `rst` also clears the countdowns.
- R8: A `dt_value` of 0 on an enabled channel gives the same behaviour as a disabled channel.
- R9: A compare change that arrives while a channel's countdown is nonzero reloads the countdown with D, which restarts the full dead band.
- R10: The two gates of a pair are never 1 at the same time.
- R11: The channels are independent. A change on one channel does not affect the gates or the run flag of another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of all state |
| tick_en | input | 1 | Timer-rate clock enable; countdowns step only when it is 1 |
| cnt_clr | input | 1 | Synchronous clear of all countdowns |
| cmp_state | input | 3 | Compare state per channel, bit i for channel i |
| dt_value | input | 8 | Shared dead-band length in timer ticks |
| dt_enable | input | 3 | Per-channel dead-band enable |
| gate_hi | output | 3 | High-side gate per channel, active high |
| gate_lo | output | 3 | Low-side gate per channel, active high |
| dt_run | output | 3 | Per-channel flag, 1 while the countdown is nonzero |

## Verification
Some properties are checked by assertions on every cycle. These are: the two gates of a pair never both on; both gates off while a run flag is high; the countdown holding without a tick; a load capturing the shared value; a clear emptying the countdown; and a disabled channel never starting a dead band. Other behaviours need the bench's scenarios, each with a known tick count. These are the exact length of the dead band, the reload on a retrigger, a zero length acting as bypass, the gates staying off until the first tick after reset, and the independence of the channels. A tick-accurate scoreboard also compares all nine outputs over a long run of random stimulus.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int NUM_CH = 3;
    localparam int DT_W   = 8;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_DEC  = 2'd2,
        CNT_CLR  = 2'd3
    } cnt_op_e;

    // Clear wins over load, load wins over a tick step.
    function automatic cnt_op_e pick_op(
        input logic clr,
        input logic load,
        input logic tick,
        input logic nonzero
    );
        if (clr)                 return CNT_CLR;
        else if (load)           return CNT_LOAD;
        else if (tick && nonzero) return CNT_DEC;
        else                     return CNT_HOLD;
    endfunction

    // Gate selection: nothing before arming or while the countdown runs.
    function automatic gate_pair_t steer(
        input logic cmp,
        input logic cnt_zero,
        input logic armed
    );
        gate_pair_t g;
        g.hi = armed &  cmp & cnt_zero;
        g.lo = armed & ~cmp & cnt_zero;
        return g;
    endfunction

endpackage

// File: rtl/dtg_counter.sv
module dtg_counter
    import dtg_pkg::*;
#(
    parameter int W = DT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         run
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    cnt_op_e op;

    assign run = (cnt != ZERO);
    assign op  = pick_op(clr, load, tick, run);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= ZERO;
        end else begin
            unique case (op)
                CNT_CLR:  cnt <= ZERO;
                CNT_LOAD: cnt <= load_val;
                CNT_DEC:  cnt <= cnt - ONE;
                default:  cnt <= cnt;
            endcase
        end
    end

    // R6: no tick, no load, no clear -> value held
    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && !tick) |=> $stable(cnt));

    // R3: a load captures the shared length
    a_r3_load_value: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (cnt == $past(load_val)));

    // R7: clear empties the countdown
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == ZERO));

endmodule

// File: rtl/dtg_outstage.sv
module dtg_outstage
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cmp_in,
    input  logic cnt_zero,
    output logic change,
    output logic gate_hi,
    output logic gate_lo
);

    logic       cmp_q;
    logic       armed;
    gate_pair_t pair;

    assign change = (cmp_in != cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= 1'b0;
            armed <= 1'b0;
        end else begin
            cmp_q <= cmp_in;
            if (tick) armed <= 1'b1;
        end
    end

    assign pair    = steer(cmp_q, cnt_zero, armed);
    assign gate_hi = pair.hi;
    assign gate_lo = pair.lo;

    // R10: a half bridge is never driven shoot-through
    a_r10_never_both_on: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

endmodule

// File: rtl/dtg_channel.sv
module dtg_channel
    import dtg_pkg::*;
#(
    parameter int W = DT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clr,
    input  logic         cmp_in,
    input  logic         enable,
    input  logic [W-1:0] dt_len,
    output logic         gate_hi,
    output logic         gate_lo,
    output logic         run
);

    logic         change;
    logic         load;
    logic [W-1:0] cnt;

    // A zero length never starts a countdown (bypass, R8)
    assign load = change & enable & (dt_len != '0);

    dtg_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .tick     (tick),
        .load     (load),
        .load_val (dt_len),
        .cnt      (cnt),
        .run      (run)
    );

    dtg_outstage u_out (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cmp_in   (cmp_in),
        .cnt_zero (cnt == '0),
        .change   (change),
        .gate_hi  (gate_hi),
        .gate_lo  (gate_lo)
    );

    // R5: running countdown keeps both gates off
    a_r5_run_blocks_gates: assert property (@(posedge clk) disable iff (rst)
        run |-> (!gate_hi && !gate_lo));

    // R2: disabled channel never starts a dead band
    a_r2_disabled_no_start: assert property (@(posedge clk) disable iff (rst)
        (change && !enable && !run) |=> !run);

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
    import dtg_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int W    = DT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_en,
    input  logic            cnt_clr,
    input  logic [N_CH-1:0] cmp_state,
    input  logic [W-1:0]    dt_value,
    input  logic [N_CH-1:0] dt_enable,
    output logic [N_CH-1:0] gate_hi,
    output logic [N_CH-1:0] gate_lo,
    output logic [N_CH-1:0] dt_run
);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        dtg_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick_en),
            .clr     (cnt_clr),
            .cmp_in  (cmp_state[ch]),
            .enable  (dt_enable[ch]),
            .dt_len  (dt_value),
            .gate_hi (gate_hi[ch]),
            .gate_lo (gate_lo[ch]),
            .run     (dt_run[ch])
        );
    end

endmodule

// File: tb/pwm_deadband_bench.sv
module pwm_deadband_bench;

    localparam int  N     = 3;
    localparam int  W     = 8;
    localparam time T_CLK = 10ns;

    logic         clk = 1'b0;
    logic         rst, tick_en, cnt_clr;
    logic [N-1:0] cmp_state, dt_enable;
    logic [W-1:0] dt_value;
    logic [N-1:0] gate_hi, gate_lo, dt_run;

    pwm_deadband u_pwm_deadband (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_clr(cnt_clr),
        .cmp_state(cmp_state), .dt_value(dt_value), .dt_enable(dt_enable),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .dt_run(dt_run)
    );

    always #(T_CLK/2) clk = ~clk;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- scoreboard: model pushes, monitor pops ----------------
    logic [8:0]   sb_q[$];
    logic [N-1:0] m_cmp;
    logic [N-1:0] m_armed;
    int           m_cnt[N];

    always @(posedge clk) begin
        logic [8:0] e;
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                m_cmp[i] = 1'b0; m_armed[i] = 1'b0; m_cnt[i] = 0;
            end else begin
                if (cnt_clr) m_cnt[i] = 0;
                else if (cmp_state[i] != m_cmp[i] && dt_enable[i] && dt_value != 0)
                    m_cnt[i] = int'(dt_value);
                else if (tick_en && m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
                m_cmp[i] = cmp_state[i];
                if (tick_en) m_armed[i] = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) begin
            e[6+i] = m_armed[i] &&  m_cmp[i] && m_cnt[i] == 0;
            e[3+i] = m_armed[i] && !m_cmp[i] && m_cnt[i] == 0;
            e[i]   = m_cnt[i] != 0;
        end
        sb_q.push_back(e);
    end

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            logic [8:0] e;
            e = sb_q.pop_front();
            chk(cur_req, {gate_hi, gate_lo, dt_run}, e);
            chk("R10", gate_hi & gate_lo, 0);
        end
    end

    // ---------------- driver ----------------
    task automatic cyc(input logic t);
        tick_en = t;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    bit done = 0;

    initial begin
        rst = 1'b1; tick_en = 0; cnt_clr = 0;
        cmp_state = '0; dt_enable = '0; dt_value = '0;
        @(negedge clk);
        repeat (3) cyc(0);

        // R1: reset state, passive until first tick
        cur_req = "R1";
        rst = 1'b0;
        chk("R1", {gate_hi, gate_lo, dt_run}, 0);
        cyc(0); cyc(0);
        chk("R1", {gate_hi, gate_lo, dt_run}, 0);
        cyc(1);
        chk("R1", {gate_hi, gate_lo}, {3'b000, 3'b111});

        // R2 / R4: disabled channel switches at next edge
        cur_req = "R2";
        dt_enable = 3'b000; dt_value = 8'd4; cmp_state = 3'b001;
        cyc(0);
        chk("R2", {gate_hi[0], gate_lo[0], dt_run[0]}, 3'b100);

        // R3 / R5 / R6: enabled channel 1, D=5
        cur_req = "R3";
        dt_enable = 3'b010; dt_value = 8'd5; cmp_state = 3'b011;
        cyc(0);
        chk("R5", {gate_hi[1], gate_lo[1], dt_run[1]}, 3'b001);
        repeat (3) cyc(0);
        chk("R6", {gate_hi[1], dt_run[1]}, 2'b01);
        for (int k = 1; k <= 5; k++) begin
            cyc(1);
            chk("R3", {gate_hi[1], dt_run[1]}, (k == 5) ? 2'b10 : 2'b01);
        end

        // R4: on->off immediate, off->on delayed
        cur_req = "R4";
        cmp_state = 3'b001;
        cyc(0);
        chk("R4", {gate_hi[1], gate_lo[1], dt_run[1]}, 3'b001);
        repeat (5) cyc(1);
        chk("R4", {gate_hi[1], gate_lo[1], dt_run[1]}, 3'b010);

        // R8: zero length acts as bypass
        cur_req = "R8";
        dt_enable = 3'b100; dt_value = 8'd0; cmp_state = 3'b101;
        cyc(0);
        chk("R8", {gate_hi[2], gate_lo[2], dt_run[2]}, 3'b100);

        // R9: retrigger reloads the full length
        cur_req = "R9";
        dt_enable = 3'b001; dt_value = 8'd6; cmp_state = 3'b100;
        cyc(0);
        chk("R9", {gate_hi[0], gate_lo[0], dt_run[0]}, 3'b001);
        repeat (3) cyc(1);
        cmp_state = 3'b101;
        cyc(0);
        chk("R9", dt_run[0], 1'b1);
        repeat (5) cyc(1);
        chk("R9", {gate_hi[0], dt_run[0]}, 2'b01);
        cyc(1);
        chk("R9", {gate_hi[0], dt_run[0]}, 2'b10);

        // R7: dedicated clear and system reset empty countdowns
        cur_req = "R7";
        dt_enable = 3'b100; dt_value = 8'd6; cmp_state = 3'b001;
        cyc(0);
        chk("R7", {gate_lo[2], dt_run[2]}, 2'b01);
        cnt_clr = 1'b1;
        cyc(0);
        cnt_clr = 1'b0;
        chk("R7", {gate_lo[2], dt_run[2]}, 2'b10);
        dt_enable = 3'b111; cmp_state = 3'b000;
        cyc(0);
        chk("R7", dt_run[0], 1'b1);
        cur_req = "R1";
        rst = 1'b1;
        cyc(0);
        rst = 1'b0;
        chk("R7", {gate_hi, gate_lo, dt_run}, 0);
        cyc(0);
        chk("R1", {gate_hi, gate_lo, dt_run}, 0);
        cyc(1);
        chk("R1", {gate_hi, gate_lo}, {3'b000, 3'b111});

        // R11: channels independent
        cur_req = "R11";
        dt_enable = 3'b111; dt_value = 8'd3; cmp_state = 3'b001;
        cyc(0);
        chk("R11", {dt_run, gate_hi[2:1], gate_lo[2:1]}, {3'b001, 2'b00, 2'b11});
        repeat (3) cyc(1);
        chk("R11", {gate_hi, gate_lo, dt_run}, {3'b001, 3'b110, 3'b000});

        // Random run against the scoreboard
        cur_req = "R3";
        for (int c = 0; c < 3000; c++) begin
            if ($urandom_range(0, 5) == 0) cmp_state = 3'($urandom);
            if ($urandom_range(0, 40) == 0) dt_enable = 3'($urandom);
            if ($urandom_range(0, 60) == 0) dt_value = 8'($urandom_range(0, 7));
            cnt_clr = ($urandom_range(0, 80) == 0);
            cyc($urandom_range(0, 2) != 0);
        end
        cnt_clr = 1'b0;
        repeat (2) cyc(0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(T_CLK * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule